// File: doc/BRIEF.md
# Write-Through Direct-Mapped Cache with Four-Word Lines

This block is a 64 KB direct-mapped data cache. It sits between a processor request port and a slower main-memory port. Each line holds four 32-bit words, one valid flag and a 16-bit tag. The block splits a 32-bit byte address into a tag, a line index, a word select and a byte offset. A read that hits completes in the cycle it is presented. A read that misses first waits until every posted write has reached memory. It then reads all four words of the line from memory, lowest word first, and installs the whole line. On the next cycle the held request completes as a hit.

Writes use a write-through policy with a small posted buffer. A write that hits updates the cached word. Every write, hit or miss, is queued as an address/data pair in a four-entry FIFO. The FIFO drains to memory one entry per completed handshake. A write miss does not allocate a line. The processor waits only when the FIFO is full.

The processor holds `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady until `cpu_ready` is high. The memory port holds `mem_req` and its address, direction and data until the cycle in which `mem_ack` is high.

Top module: `wt_cache`

## Requirements
- R1: Address fields are: tag = bits 31..16, line index = bits 15..4 (4096 lines), word select = bits 3..2, byte offset = bits 1..0. The byte offset does not change which word a read returns. Words 0..3 of a line sit at byte offsets 0x0, 0x4, 0x8 and 0xC.
- R2: After reset, `mem_req` is low and every line is invalid, so the first read of any address is a miss.
- R3: A read whose line is valid with a matching tag raises `cpu_ready` in the same cycle. In that cycle `cpu_rdata` is the addressed word.
- R4: A read miss keeps `cpu_ready` low and issues exactly four memory reads (`mem_we`=0), at the line base plus 0x0, 0x4, 0x8 and 0xC in that order. Tag and valid are set after the fourth word arrives. The held read then completes with memory's word.
- R5: A write is accepted (`cpu_ready` high in its cycle) whenever the buffer holds fewer than four entries. It is queued with its address rounded down to a word boundary. If the line is present, the cached word takes the new data, and later reads return it.
- R6: A write miss does not allocate a line, so a later read of that line is still a miss.
- R7: Queued writes reach memory oldest first, one per handshake, with `mem_we`=1 and the queued address and data.
- R8: No line-fill read is issued while any queued write is pending. A read therefore always returns the newest value written to its address.
- R9: While four writes are queued, a write request sees `cpu_ready` low.
- R10: A read miss to an index that holds another tag replaces that line. The old address misses on its next read.
- R11: Once raised, `mem_req` stays high with stable `mem_addr`, `mem_we` and `mem_wdata` until the cycle that has `mem_ack` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Request completes in this cycle |
| cpu_rdata | output | 32 | Read data, valid when a read completes |
| mem_req | output | 1 | Memory request present |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the current request |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
Directed sequences cover several cases. All four word selects and a non-zero byte offset on one line separate the word multiplexer from the byte offset. A write hit followed by a read shows the cached copy being updated. A write miss followed by a read of the same address shows that there is no allocation and that fills wait for the buffer to drain. Six back-to-back writes against a slow memory expose the full-buffer stall. Two tags on the same index show eviction, and the highest index and word check the edge of the field decoding. A long pseudo-random mix follows, over four tags and four indices with memory latency varying from 0 to 2 cycles. It tells apart ordering faults, such as a fill racing a pending write or drain order, from plain data-path faults.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_FILL  = 2'd2
    } fill_state_e;

endpackage

// File: rtl/wt_line_store.sv
module wt_line_store #(
    parameter int INDEX_W    = 12,
    parameter int TAG_W      = 16,
    parameter int WSEL_W     = 2,
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [INDEX_W-1:0]                 lk_index,
    input  logic [TAG_W-1:0]                   lk_tag,
    input  logic [WSEL_W-1:0]                  lk_wsel,
    output logic                               lk_hit,
    output logic [DATA_W-1:0]                  lk_word,
    input  logic                               word_we,
    input  logic [DATA_W-1:0]                  word_data,
    input  logic                               fill_en,
    input  logic [LINE_WORDS-1:0][DATA_W-1:0]  fill_line
);

    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0] valid_d, valid_q;
    logic [TAG_W-1:0] tag_mem [LINES];
    logic [LINE_WORDS-1:0][DATA_W-1:0] word_rd;

    // next-state of the valid flags: a completed fill marks its line
    always_comb begin
        valid_d = valid_q;
        if (fill_en) begin
            valid_d[lk_index] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            valid_q <= valid_d;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_mem[lk_index] <= lk_tag;
        end
    end

    // one storage bank per word position of a line
    generate
        for (genvar w = 0; w < LINE_WORDS; w++) begin : g_bank
            logic [DATA_W-1:0] bank [LINES];

            always_ff @(posedge clk) begin
                if (fill_en) begin
                    bank[lk_index] <= fill_line[w];
                end else if (word_we && (lk_wsel == WSEL_W'(w))) begin
                    bank[lk_index] <= word_data;
                end
            end

            assign word_rd[w] = bank[lk_index];
        end
    endgenerate

    assign lk_hit  = valid_q[lk_index] && (tag_mem[lk_index] == lk_tag);
    assign lk_word = word_rd[lk_wsel];

endmodule

// File: rtl/wt_post_fifo.sv
module wt_post_fifo #(
    parameter int DEPTH  = 4,
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [AW-1:0]    push_addr,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [AW-1:0]    head_addr,
    output logic [DW-1:0]    head_data,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] level
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [PTR_W-1:0]         wr_ptr;
        logic [PTR_W-1:0]         rd_ptr;
        logic [CNT_W-1:0]         count;
    } fifo_t;

    fifo_t fifo_d, fifo_q;
    logic  do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        fifo_d  = fifo_q;
        do_push = push && (fifo_q.count != CNT_W'(DEPTH));
        do_pop  = pop && (fifo_q.count != '0);
        if (do_push) begin
            fifo_d.addr[fifo_q.wr_ptr] = push_addr;
            fifo_d.data[fifo_q.wr_ptr] = push_data;
            fifo_d.wr_ptr              = bump(fifo_q.wr_ptr);
        end
        if (do_pop) begin
            fifo_d.rd_ptr = bump(fifo_q.rd_ptr);
        end
        unique case ({do_push, do_pop})
            2'b10:   fifo_d.count = fifo_q.count + 1'b1;
            2'b01:   fifo_d.count = fifo_q.count - 1'b1;
            default: fifo_d.count = fifo_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_q <= '0;
        end else begin
            fifo_q <= fifo_d;
        end
    end

    assign head_addr = fifo_q.addr[fifo_q.rd_ptr];
    assign head_data = fifo_q.data[fifo_q.rd_ptr];
    assign empty     = (fifo_q.count == '0);
    assign full      = (fifo_q.count == CNT_W'(DEPTH));
    assign level     = fifo_q.count;

endmodule

// File: rtl/wt_miss_ctrl.sv
module wt_miss_ctrl
    import wt_cache_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int WSEL_W     = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cpu_req,
    input  logic                               cpu_we,
    input  logic                               lk_hit,
    input  logic                               wb_empty,
    input  logic                               wb_full,
    input  logic                               mem_ack,
    input  logic [DATA_W-1:0]                  mem_rdata,
    output logic                               cpu_ready,
    output logic                               wb_push,
    output logic                               word_we,
    output logic                               fill_req,
    output logic [WSEL_W-1:0]                  fill_wsel,
    output logic                               fill_en,
    output logic [LINE_WORDS-1:0][DATA_W-1:0]  fill_line,
    output logic                               drain_ok
);

    localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(LINE_WORDS - 1);

    typedef struct packed {
        fill_state_e                      state;
        logic [WSEL_W-1:0]                wsel;
        logic [LINE_WORDS-1:0][DATA_W-1:0] gather;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  rd_req, wr_req;
    logic [LINE_WORDS-1:0][DATA_W-1:0] merged;

    always_comb begin
        ctrl_d    = ctrl_q;
        rd_req    = cpu_req && !cpu_we;
        wr_req    = cpu_req && cpu_we;
        cpu_ready = 1'b0;
        wb_push   = 1'b0;
        word_we   = 1'b0;
        fill_req  = 1'b0;
        fill_en   = 1'b0;

        // gathered words with the arriving word placed at its slot
        merged              = ctrl_q.gather;
        merged[ctrl_q.wsel] = mem_rdata;

        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (rd_req) begin
                    if (lk_hit) begin
                        cpu_ready = 1'b1;
                    end else begin
                        ctrl_d.wsel  = '0;
                        ctrl_d.state = wb_empty ? ST_FILL : ST_DRAIN;
                    end
                end else if (wr_req && !wb_full) begin
                    cpu_ready = 1'b1;
                    wb_push   = 1'b1;
                    word_we   = lk_hit;
                end
            end
            ST_DRAIN: begin
                if (wb_empty) begin
                    ctrl_d.state = ST_FILL;
                end
            end
            ST_FILL: begin
                fill_req = 1'b1;
                if (mem_ack) begin
                    ctrl_d.gather = merged;
                    ctrl_d.wsel   = ctrl_q.wsel + 1'b1;
                    if (ctrl_q.wsel == LAST_WORD) begin
                        fill_en      = 1'b1;
                        ctrl_d.state = ST_IDLE;
                    end
                end
            end
            default: ctrl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '{state: ST_IDLE, wsel: '0, gather: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign fill_wsel = ctrl_q.wsel;
    assign fill_line = merged;
    assign drain_ok  = (ctrl_q.state != ST_FILL);

endmodule

// File: rtl/wt_cache.sv
module wt_cache #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int INDEX_W    = 12,
    parameter int LINE_WORDS = 4,
    parameter int WB_DEPTH   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int WSEL_W = $clog2(LINE_WORDS);
    localparam int TAG_W  = ADDR_W - INDEX_W - WSEL_W - BYTE_W;
    localparam int CNT_W  = $clog2(WB_DEPTH + 1);

    logic [TAG_W-1:0]   lk_tag;
    logic [INDEX_W-1:0] lk_index;
    logic [WSEL_W-1:0]  lk_wsel;
    logic               lk_hit;
    logic               unused_byte;

    logic               wb_push, wb_pop, wb_empty, wb_full;
    logic [ADDR_W-1:0]  wb_head_addr;
    logic [DATA_W-1:0]  wb_head_data;
    logic [CNT_W-1:0]   wb_level;

    logic               word_we, fill_req, fill_en, drain_ok;
    logic [WSEL_W-1:0]  fill_wsel;
    logic [LINE_WORDS-1:0][DATA_W-1:0] fill_line;

    // address decode
    assign lk_tag      = cpu_addr[ADDR_W-1 -: TAG_W];
    assign lk_index    = cpu_addr[BYTE_W + WSEL_W +: INDEX_W];
    assign lk_wsel     = cpu_addr[BYTE_W +: WSEL_W];
    assign unused_byte = ^cpu_addr[BYTE_W-1:0];

    wt_line_store #(
        .INDEX_W   (INDEX_W),
        .TAG_W     (TAG_W),
        .WSEL_W    (WSEL_W),
        .DATA_W    (DATA_W),
        .LINE_WORDS(LINE_WORDS)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_index (lk_index),
        .lk_tag   (lk_tag),
        .lk_wsel  (lk_wsel),
        .lk_hit   (lk_hit),
        .lk_word  (cpu_rdata),
        .word_we  (word_we),
        .word_data(cpu_wdata),
        .fill_en  (fill_en),
        .fill_line(fill_line)
    );

    wt_post_fifo #(
        .DEPTH(WB_DEPTH),
        .AW   (ADDR_W),
        .DW   (DATA_W),
        .CNT_W(CNT_W)
    ) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (wb_push),
        .push_addr({cpu_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}}),
        .push_data(cpu_wdata),
        .pop      (wb_pop),
        .head_addr(wb_head_addr),
        .head_data(wb_head_data),
        .empty    (wb_empty),
        .full     (wb_full),
        .level    (wb_level)
    );

    wt_miss_ctrl #(
        .DATA_W    (DATA_W),
        .LINE_WORDS(LINE_WORDS),
        .WSEL_W    (WSEL_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_req  (cpu_req),
        .cpu_we   (cpu_we),
        .lk_hit   (lk_hit),
        .wb_empty (wb_empty),
        .wb_full  (wb_full),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .cpu_ready(cpu_ready),
        .wb_push  (wb_push),
        .word_we  (word_we),
        .fill_req (fill_req),
        .fill_wsel(fill_wsel),
        .fill_en  (fill_en),
        .fill_line(fill_line),
        .drain_ok (drain_ok)
    );

    // memory port: a fill owns it; otherwise the buffer head drains
    assign mem_req   = fill_req || (drain_ok && !wb_empty);
    assign mem_we    = !fill_req;
    assign mem_addr  = fill_req
                     ? {cpu_addr[ADDR_W-1:WSEL_W+BYTE_W], fill_wsel, {BYTE_W{1'b0}}}
                     : wb_head_addr;
    assign mem_wdata = wb_head_data;
    assign wb_pop    = mem_req && mem_we && mem_ack;

endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int WB_DEPTH = 4,
    parameter int CNT_W    = $clog2(WB_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              lk_hit,
    input logic              wb_full,
    input logic [CNT_W-1:0]  wb_level
);

    // R3: a present line answers a read in the same cycle
    a_r3_hit_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && !cpu_we && lk_hit |-> cpu_ready);

    // R5: an accepted write adds one queued entry unless one drains meanwhile
    a_r5_push_count: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_we && cpu_ready && !(mem_req && mem_we && mem_ack)
        |=> wb_level == CNT_W'($past(wb_level) + 1'b1));

    // R8: fill reads only with nothing queued
    a_r8_fill_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we |-> wb_level == '0);

    // R9: a full buffer refuses writes
    a_r9_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_we && wb_full |-> !cpu_ready);

    // R9: occupancy never exceeds the depth
    a_r9_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        wb_level <= CNT_W'(WB_DEPTH));

    // R11: a pending memory request is held unchanged
    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wdata));

endmodule

bind wt_cache wt_cache_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .WB_DEPTH(WB_DEPTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_we   (cpu_we),
    .cpu_ready(cpu_ready),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .lk_hit   (lk_hit),
    .wb_full  (wb_full),
    .wb_level (wb_level)
);

// File: tb/test_wt_cache.sv
`timescale 1ns/1ps
module test_wt_cache;

    logic        clk = 1'b0;
    logic        rst_n, cpu_req, cpu_we, cpu_ready;
    logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    always #2.5 clk = ~clk;

    wt_cache i_wt_cache (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [31:0] data;
        string       tag;
    } op_t;

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
    } post_t;

    int          n_checks = 0;
    int          n_errors = 0;
    int          total_cycles = 0;
    op_t         ops[$];
    op_t         cur;
    bit          cur_valid = 0;
    post_t       wq[$];
    bit          mv[int];
    logic [15:0] mt[int];
    logic [31:0] arch[int];
    logic [31:0] mm[int];
    int          fill_w = 0;
    int          wcnt = 0;
    int          lat_base = 1;
    bit          lat_rand = 0;
    int          lat = 1;
    bit          hung = 0;
    bit          prev_wait = 0;
    logic [31:0] prev_addr, prev_wdata;
    logic        prev_we;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    function automatic logic [31:0] next_rand();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr;
    endfunction

    function automatic logic [31:0] init_val(logic [31:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [31:0] mem_val(logic [31:0] a);
        return mm.exists(int'(a)) ? mm[int'(a)] : init_val(a);
    endfunction

    function automatic logic [31:0] arch_val(logic [31:0] a);
        return arch.exists(int'(a)) ? arch[int'(a)] : init_val(a);
    endfunction

    function automatic bit model_hit(logic [31:0] a);
        int idx = int'(a[15:4]);
        return mv.exists(idx) && (mt[idx] == a[31:16]);
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp, string what);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic void add(bit we, logic [31:0] addr, logic [31:0] data, string tag);
        op_t o;
        o.we = we; o.addr = addr; o.data = data; o.tag = tag;
        ops.push_back(o);
    endfunction

    // one clock of stimulus, checking and model update
    task automatic step();
        bit          exp_ready;
        logic [31:0] wa;
        int          idx;
        @(negedge clk);
        if (mem_req && wcnt >= lat) begin
            mem_ack   = 1'b1;
            mem_rdata = mem_val(mem_addr);
        end else begin
            mem_ack   = 1'b0;
            mem_rdata = 32'h0;
        end
        if (!cur_valid && ops.size() > 0) begin
            cur       = ops.pop_front();
            cur_valid = 1;
        end
        cpu_req   = cur_valid;
        cpu_we    = cur_valid && cur.we;
        cpu_addr  = cur_valid ? cur.addr : 32'h0;
        cpu_wdata = cur_valid ? cur.data : 32'h0;
        #2;
        if (prev_wait) begin
            chk(mem_req && mem_addr == prev_addr && mem_we == prev_we &&
                (!mem_we || mem_wdata == prev_wdata), "R11", mem_addr, prev_addr,
                "request changed before ack");
        end
        prev_wait  = mem_req && !mem_ack;
        prev_addr  = mem_addr;
        prev_we    = mem_we;
        prev_wdata = mem_wdata;
        if (cur_valid) begin
            wa = {cur.addr[31:2], 2'b00};
            exp_ready = cur.we ? (wq.size() < 4) : model_hit(cur.addr);
            chk(cpu_ready == exp_ready, cur.tag, 32'(cpu_ready), 32'(exp_ready), "cpu_ready");
            if (cpu_ready && !cur.we)
                chk(cpu_rdata == arch_val(wa), cur.tag, cpu_rdata, arch_val(wa), "read data");
        end
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                if (wq.size() == 0) begin
                    chk(0, "R7", mem_addr, 32'h0, "memory write with nothing queued");
                end else begin
                    chk(mem_addr == wq[0].a && mem_wdata == wq[0].d, "R7",
                        mem_addr ^ mem_wdata, wq[0].a ^ wq[0].d, "drain order addr^data");
                    mm[int'(mem_addr)] = mem_wdata;
                    void'(wq.pop_front());
                end
            end else begin
                chk(wq.size() == 0, "R8", 32'(wq.size()), 32'h0, "fill read with writes queued");
                chk(cur_valid && mem_addr == {cur.addr[31:4], 2'(fill_w), 2'b00}, "R4",
                    mem_addr, {cur.addr[31:4], 2'(fill_w), 2'b00}, "fill address");
                fill_w++;
                if (fill_w == 4) begin
                    fill_w  = 0;
                    idx     = int'(cur.addr[15:4]);
                    mv[idx] = 1;
                    mt[idx] = cur.addr[31:16];
                end
            end
            wcnt = 0;
            lat  = lat_rand ? int'(next_rand() % 3) : lat_base;
        end else if (mem_req) begin
            wcnt++;
        end
        if (cur_valid && cpu_ready) begin
            if (cur.we) begin
                post_t p;
                p.a = {cur.addr[31:2], 2'b00};
                p.d = cur.data;
                wq.push_back(p);
                arch[int'(p.a)] = cur.data;
            end
            cur_valid = 0;
        end
    endtask

    task automatic run_ops();
        int idle = 0;
        while (!hung) begin
            step();
            total_cycles++;
            idle++;
            if (!cur_valid || mem_ack) idle = 0;
            if (!cur_valid && ops.size() == 0 && wq.size() == 0) break;
            if (idle > 2000 || total_cycles > 150000) begin
                hung = 1;
                chk(0, "WATCHDOG", 32'(total_cycles), 32'h0, "run did not finish");
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        mem_ack = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mv.delete(); mt.delete(); wq.delete();
        fill_w = 0; wcnt = 0; cur_valid = 0; prev_wait = 0;
        #2;
        chk(mem_req == 1'b0, "R2", 32'(mem_req), 32'h0, "mem_req after reset");
        chk(cpu_ready == 1'b0, "R2", 32'(cpu_ready), 32'h0, "cpu_ready idle after reset");
    endtask

    initial begin
        logic [15:0] tags [4] = '{16'h0001, 16'h0002, 16'h00F0, 16'hFFFF};
        logic [11:0] idxs [4] = '{12'h234, 12'h000, 12'hFFF, 12'h235};
        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        mem_ack = 1'b0; mem_rdata = '0;
        do_reset();

        // R4 cold miss, then R3/R1 word select and byte offset on one line
        lat_base = 1; lat = 1;
        add(0, 32'h0001_2340, 0, "R4");
        add(0, 32'h0001_2340, 0, "R3");
        add(0, 32'h0001_2344, 0, "R3");
        add(0, 32'h0001_2348, 0, "R1");
        add(0, 32'h0001_234C, 0, "R3");
        add(0, 32'h0001_2346, 0, "R1");
        // R5 write hit updates the cached word
        add(1, 32'h0001_2344, 32'hDEAD_0001, "R5");
        add(0, 32'h0001_2344, 0, "R5");
        // R6 write miss does not allocate; R8 the fill waits and sees new data
        add(1, 32'h0005_6780, 32'h1111_2222, "R6");
        add(0, 32'h0005_6780, 0, "R6");
        add(0, 32'h0005_6780, 0, "R8");
        run_ops();

        // R9 six writes against slow memory
        lat_base = 5; lat = 5;
        add(1, 32'h0007_0000, 32'hA000_0000, "R9");
        add(1, 32'h0007_0004, 32'hA000_0001, "R9");
        add(1, 32'h0007_0008, 32'hA000_0002, "R9");
        add(1, 32'h0007_000C, 32'hA000_0003, "R9");
        add(1, 32'h0007_0010, 32'hA000_0004, "R9");
        add(1, 32'h0007_0014, 32'hA000_0005, "R9");
        run_ops();

        // R10 conflict on index 0x234; R1 highest index and word
        lat_base = 0; lat = 0;
        add(0, 32'h0002_2340, 0, "R10");
        add(0, 32'h0001_2344, 0, "R10");
        add(0, 32'hFFFF_FFFC, 0, "R1");
        add(0, 32'hFFFF_FFF0, 0, "R3");
        run_ops();

        // mixed pseudo-random traffic
        lat_rand = 1;
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = next_rand();
            add(r[8], {tags[r[1:0]], idxs[r[3:2]], r[5:4], r[7:6]}, next_rand(),
                r[8] ? "R5" : "R3");
        end
        run_ops();

        // R2 a second reset invalidates a line that was present
        lat_rand = 0; lat_base = 1; lat = 1;
        do_reset();
        add(0, 32'h0001_2344, 0, "R2");
        run_ops();

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule